// File: doc/BRIEF.md
# Chained Start Trigger for Two Up-Counting Timers

Two identical up-counting timers share an internal trigger path. Each timer picks an internal event to drive out as its trigger output. It can also take a trigger from one of two sources: the other timer's trigger output or a rising edge on its own capture pin. In event mode an accepted trigger sets the timer's enable bit, so counting starts, and nothing the trigger source does later stops it again.

A timer that is started by its capture pin can forward its enable to the other timer. If that first timer also has its synchronisation bit set, it holds back its own start by one cycle. This matches the one-cycle latency of the internal trigger path, so both counters increment for the first time on the same clock edge. Every accepted trigger also sets a sticky flag in the timer that accepted it.

All control fields are written through a single write port. The port selects a timer, one of four registers and a data word.

Top module: `trig_chain_timers`

## Requirements
- R1: After reset every counter reads 0, every enable output is 0 and every trigger flag is 0. The reload value resets to all ones.
- R2: Register 0 is the control word. Its fields are: bit 0 enable, bits 3:1 trigger-output select, bits 6:4 trigger source, bits 9:7 slave action and bit 10 synchronisation. Register 1 is the reload value. While enabled, the counter adds one per clock and goes to 0 on the clock after it equals the reload value. A control write to enable takes effect on that edge, and the first increment follows on the next edge.
- R3: With trigger-output select 3'b001, a timer's trigger output follows its enable. A second timer with trigger source 3'b010 and slave action 3'b110 sets its enable one clock after the first timer's enable rises.
- R4: Trigger source 3'b100 takes the timer's own capture input. The input is sampled, and the enable becomes set on the second clock edge after the input rises.
- R5: Once set in event mode, the enable stays set when the trigger source falls. Only a control write clears it.
- R6: When the synchronisation bit is set on the capture-triggered timer, its own enable is delayed by one clock. Both counters then hold equal values from the start.
- R7: Each rising edge of the selected trigger source sets the timer's flag, whatever the slave action is. The flag stays set until register 2 is written with bit 0 equal to 0. Writing bit 0 equal to 1 has no effect.
- R8: A slave action other than 3'b110 never sets the enable from a trigger.
- R9: A trigger source other than 3'b010 or 3'b100 produces no trigger, so it sets neither the enable nor the flag.
- R10: Trigger-output select 3'b010 sends a one-clock pulse on each counter wrap. A slave chained to this output starts one clock after the wrap.
- R11: Writing register 3 loads the counter directly. A load takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SEL_W (1) | Timer selected for the write |
| wr_addr_i | input | 2 | Register: 0 control, 1 reload, 2 flag, 3 counter |
| wr_data_i | input | CNT_W (16) | Write data |
| cap_i | input | N_TMR (2) | Capture input, one bit per timer |
| cnt_o | output | N_TMR x CNT_W | Counter values |
| cen_o | output | N_TMR (2) | Enable bit of each timer |
| trig_flag_o | output | N_TMR (2) | Sticky trigger flag of each timer |

## Verification
The embedded assertions check the following on every cycle:
- an enabled timer keeps its enable without a control write;
- a pending synchronised start always turns into an enable on the next clock;
- a flag never drops without a clearing write, and every trigger sets its flag;
- a counter steps by exactly one, or wraps to zero.

Some behaviour depends on exact cycle counts across both timers, and only the bench scenarios can show it. This covers the one-clock slave lag, the two-clock capture latency, the equal counts in synchronised mode and the start of a slave on a wrap pulse. The same applies to the end count of randomly reloaded, preloaded and timed runs.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
  localparam logic [2:0] MM_EN  = 3'b001;
  localparam logic [2:0] MM_UPD = 3'b010;
  localparam logic [2:0] TS_ITR = 3'b010;
  localparam logic [2:0] TS_CAP = 3'b100;
  localparam logic [2:0] SM_EVT = 3'b110;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_RELOAD = 2'd1;
  localparam logic [1:0] A_FLAG   = 2'd2;
  localparam logic [1:0] A_CNT    = 2'd3;

  typedef struct packed {
    logic       msync;
    logic [2:0] smode;
    logic [2:0] tsel;
    logic [2:0] mms;
    logic       cen;
  } ctrl_t;
endpackage

// File: rtl/tc_trig_sel.sv
`timescale 1ns/1ps
module tc_trig_sel
  import tc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] tsel_i,
  input  logic       itr_i,
  input  logic       cap_i,
  output logic       trg_o
);
  logic cap_s1, cap_s2, itr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_s1 <= 1'b0;
      cap_s2 <= 1'b0;
      itr_q  <= 1'b0;
    end else begin
      cap_s1 <= cap_i;
      cap_s2 <= cap_s1;
      itr_q  <= itr_i;
    end
  end

  // internal source is already in this clock domain: one register of latency
  always_comb begin
    unique case (tsel_i)
      TS_ITR:  trg_o = itr_i & ~itr_q;
      TS_CAP:  trg_o = cap_s1 & ~cap_s2;
      default: trg_o = 1'b0;
    endcase
  end

  assert_single_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsel_i == TS_ITR && trg_o) |=> (tsel_i != TS_ITR || !trg_o));
  assert_no_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsel_i != TS_ITR && tsel_i != TS_CAP) |-> !trg_o);
endmodule

// File: rtl/tc_counter.sv
`timescale 1ns/1ps
module tc_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         wrap_q;
  logic         at_top;

  assign at_top = (cnt_q == reload_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= en_i && !ld_i && at_top;
      if (ld_i)      cnt_q <= ld_val_i;
      else if (en_i) cnt_q <= at_top ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i && !at_top) |=> (cnt_o == $past(cnt_o) + 1'b1));
  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i && at_top) |=> (cnt_o == '0));
  assert_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_o == $past(ld_val_i)));
  assert_wrap_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (cnt_o == '0));
endmodule

// File: rtl/tc_timer.sv
`timescale 1ns/1ps
module tc_timer
  import tc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] data_i,
  input  logic         cap_i,
  input  logic         itr_i,
  output logic         trgo_o,
  output logic         cen_o,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t        ctrl_q;
  logic [W-1:0] reload_q;
  logic         pend_q, flag_q;
  logic         trg, acc_evt, ctrl_wr, flag_clr, cnt_ld, wrap;

  tc_trig_sel u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tsel_i (ctrl_q.tsel),
    .itr_i  (itr_i),
    .cap_i  (cap_i),
    .trg_o  (trg)
  );

  assign ctrl_wr  = wr_i && addr_i == A_CTRL;
  assign flag_clr = wr_i && addr_i == A_FLAG && !data_i[0];
  assign cnt_ld   = wr_i && addr_i == A_CNT;
  assign acc_evt  = trg && ctrl_q.smode == SM_EVT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_t'(data_i[CTRL_W-1:0]);
      pend_q <= 1'b0;
    end else begin
      if (pend_q) begin
        ctrl_q.cen <= 1'b1;
        pend_q     <= 1'b0;
      end
      // sync option: hold own start one cycle to match the slave's path latency
      if (acc_evt) begin
        if (ctrl_q.msync) pend_q     <= 1'b1;
        else              ctrl_q.cen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          reload_q <= '1;
    else if (wr_i && addr_i == A_RELOAD) reload_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (trg)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  tc_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl_q.cen),
    .ld_i     (cnt_ld),
    .ld_val_i (data_i),
    .reload_i (reload_q),
    .cnt_o    (cnt_o),
    .wrap_o   (wrap)
  );

  always_comb begin
    unique case (ctrl_q.mms)
      MM_EN:   trgo_o = ctrl_q.cen | pend_q;
      MM_UPD:  trgo_o = wrap;
      default: trgo_o = 1'b0;
    endcase
  end

  assign cen_o  = ctrl_q.cen;
  assign flag_o = flag_q;

  assert_evt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.cen && !ctrl_wr) |=> ctrl_q.cen);
  assert_sync_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ctrl_wr) |=> (ctrl_q.cen && !pend_q));
  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg |=> flag_q);
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr) |=> flag_q);
  assert_no_evt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.smode != SM_EVT && !ctrl_q.cen && !pend_q && !ctrl_wr) |=> !ctrl_q.cen);
endmodule

// File: rtl/trig_chain_timers.sv
`timescale 1ns/1ps
module trig_chain_timers #(
  parameter int N_TMR = 2,
  parameter int CNT_W = 16,
  parameter int SEL_W = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [SEL_W-1:0]            wr_sel_i,
  input  logic [1:0]                  wr_addr_i,
  input  logic [CNT_W-1:0]            wr_data_i,
  input  logic [N_TMR-1:0]            cap_i,
  output logic [N_TMR-1:0][CNT_W-1:0] cnt_o,
  output logic [N_TMR-1:0]            cen_o,
  output logic [N_TMR-1:0]            trig_flag_o
);
  logic [N_TMR-1:0] trgo;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam int SRC = (i + 1) % N_TMR;
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_sel_i == SEL_W'(i));

    tc_timer #(.W(CNT_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_hit),
      .addr_i (wr_addr_i),
      .data_i (wr_data_i),
      .cap_i  (cap_i[i]),
      .itr_i  (trgo[SRC]),
      .trgo_o (trgo[i]),
      .cen_o  (cen_o[i]),
      .cnt_o  (cnt_o[i]),
      .flag_o (trig_flag_o[i])
    );
  end
endmodule

// File: tb/trig_chain_timers_tb_top.sv
`timescale 1ns/1ps
module trig_chain_timers_tb_top;
  localparam logic [1:0] A_CTRL = 2'd0, A_RELOAD = 2'd1, A_FLAG = 2'd2, A_CNT = 2'd3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [0:0]       wr_sel = '0;
  logic [1:0]       wr_addr = '0;
  logic [15:0]      wr_data = '0;
  logic [1:0]       cap = '0;
  logic [1:0][15:0] cnt;
  logic [1:0]       cen;
  logic [1:0]       flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_chain_timers dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .cap_i(cap),
    .cnt_o(cnt), .cen_o(cen), .trig_flag_o(flag)
  );

  function automatic logic [15:0] ctrl(bit en, logic [2:0] mm, logic [2:0] ts,
                                       logic [2:0] sm, bit sy);
    return {5'd0, sy, sm, ts, mm, en};
  endfunction

  function automatic logic [15:0] exp_cnt(int v, int m, int r);
    return 16'((v + m) % (r + 1));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called just after a falling edge; write lands on the next rising edge
  task automatic wr(int t, logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_sel = 1'(t); wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clean();
    for (int t = 0; t < 2; t++) begin
      wr(t, A_CTRL, 16'd0);
      wr(t, A_RELOAD, 16'hffff);
      wr(t, A_CNT, 16'd0);
      wr(t, A_FLAG, 16'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cnt0", 32'(cnt[0]), 0);
    chk("R1 cnt1", 32'(cnt[1]), 0);
    chk("R1 cen", 32'(cen), 0);
    chk("R1 flag", 32'(flag), 0);

    // R2 / R11: random reload, preload and run length
    for (int it = 0; it < 20; it++) begin
      int t = int'($urandom_range(1, 0));
      int r = int'($urandom_range(20, 1));
      int v = int'($urandom_range(r, 0));
      int n = int'($urandom_range(40, 0));
      clean();
      wr(t, A_RELOAD, 16'(r));
      wr(t, A_CNT, 16'(v));
      chk("R11 load", 32'(cnt[t]), 32'(v));
      wr(t, A_CTRL, ctrl(1, 3'b000, 3'b000, 3'b000, 0));
      repeat (n) @(negedge clk);
      wr(t, A_CTRL, 16'd0);
      chk("R2 count", 32'(cnt[t]), 32'(exp_cnt(v, n + 1, r)));
    end

    // R3 / R5 / R7: software start forwarded as trigger
    clean();
    wr(0, A_CTRL, ctrl(0, 3'b000, 3'b010, 3'b110, 0));
    wr(1, A_CTRL, ctrl(1, 3'b001, 3'b000, 3'b000, 0));
    chk("R3 master on", 32'(cen[1]), 1);
    chk("R3 slave lag", 32'(cen[0]), 0);
    @(negedge clk);
    chk("R3 slave on", 32'(cen[0]), 1);
    chk("R7 slave flag", 32'(flag[0]), 1);
    wr(1, A_CTRL, ctrl(0, 3'b001, 3'b000, 3'b000, 0));
    repeat (3) @(negedge clk);
    chk("R5 master off", 32'(cen[1]), 0);
    chk("R5 slave stays", 32'(cen[0]), 1);
    wr(0, A_FLAG, 16'd1);
    chk("R7 write 1 ignored", 32'(flag[0]), 1);
    wr(0, A_FLAG, 16'd0);
    chk("R7 clear", 32'(flag[0]), 0);

    // R6: capture-triggered master with sync, slave chained
    clean();
    wr(0, A_CTRL, ctrl(0, 3'b000, 3'b010, 3'b110, 0));
    wr(1, A_CTRL, ctrl(0, 3'b001, 3'b100, 3'b110, 1));
    cap[1] = 1'b1;
    @(negedge clk);
    chk("R6 master idle", 32'(cen[1]), 0);
    @(negedge clk);
    chk("R6 master flag", 32'(flag[1]), 1);
    chk("R6 master delayed", 32'(cen[1]), 0);
    chk("R6 slave flag pending", 32'(flag[0]), 0);
    @(negedge clk);
    chk("R6 both on", 32'(cen), 3);
    chk("R6 slave flag", 32'(flag[0]), 1);
    @(negedge clk);
    chk("R6 cnt0 first", 32'(cnt[0]), 1);
    chk("R6 cnt1 first", 32'(cnt[1]), 1);
    repeat (7) @(negedge clk);
    chk("R6 aligned", 32'(cnt[0]), 32'(cnt[1]));
    cap[1] = 1'b0;

    // R4: capture trigger without sync
    clean();
    wr(1, A_CTRL, ctrl(0, 3'b000, 3'b100, 3'b110, 0));
    cap[1] = 1'b1;
    @(negedge clk);
    chk("R4 not yet", 32'(cen[1]), 0);
    @(negedge clk);
    chk("R4 started", 32'(cen[1]), 1);
    chk("R4 flag", 32'(flag[1]), 1);
    cap[1] = 1'b0;

    // R8: trigger seen but slave action not event mode
    clean();
    wr(0, A_CTRL, ctrl(0, 3'b000, 3'b010, 3'b000, 0));
    wr(1, A_CTRL, ctrl(1, 3'b001, 3'b000, 3'b000, 0));
    repeat (3) @(negedge clk);
    chk("R8 no start", 32'(cen[0]), 0);
    chk("R8 R7 flag still set", 32'(flag[0]), 1);

    // R9: unused trigger source
    clean();
    wr(0, A_CTRL, ctrl(0, 3'b000, 3'b011, 3'b110, 0));
    wr(1, A_CTRL, ctrl(1, 3'b001, 3'b000, 3'b000, 0));
    repeat (3) @(negedge clk);
    chk("R9 no start", 32'(cen[0]), 0);
    chk("R9 no flag", 32'(flag[0]), 0);

    // R10: wrap pulse as trigger output
    clean();
    wr(1, A_RELOAD, 16'd3);
    wr(0, A_CTRL, ctrl(0, 3'b000, 3'b010, 3'b110, 0));
    wr(1, A_CTRL, ctrl(1, 3'b010, 3'b000, 3'b000, 0));
    repeat (3) @(negedge clk);
    chk("R10 at top", 32'(cnt[1]), 3);
    chk("R10 slave idle", 32'(cen[0]), 0);
    @(negedge clk);
    chk("R10 wrapped", 32'(cnt[1]), 0);
    chk("R10 slave lag", 32'(cen[0]), 0);
    @(negedge clk);
    chk("R10 slave on", 32'(cen[0]), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule